// File: doc/BRIEF.md
# Scan-Chain Debug Register File

This block is a bank of debug registers that a host reaches through one JTAG data-register scan path. Each scan moves a 38-bit frame through the block, least significant bit first. Bits 31:0 of the frame carry a data word, bits 36:32 carry a 5-bit register address, and bit 37 selects the direction. When Update-DR arrives with the direction bit set, the data word is written into the addressed register. When it arrives with the bit clear, only the address is stored as a read pointer. The register it names is loaded into the data field at the next Capture-DR. Reads therefore run one scan behind. The address carried by the following frame decides what the scan after that returns.

Toward the debug logic, the block drives the debug control word (including a monitor-mode enable), the vector-catch mask and the registers of every watch unit. It also carries two single-word mailboxes, and each one is a valid/ready stream. A host write to the mailbox address offers a word to the target; the offer stays up until the target accepts it. The target pushes words toward the host; each capture taken while the read pointer names the mailbox consumes the word it captures. Because that read has a side effect, a host must move the read pointer to a harmless address before its last scan. All logic runs on TCK. The TAP state machine and the selection of the scan chain sit outside the block.

Top module: `jtag_dbg_regs`

## Requirements
- R1: After reset the stored registers are zero, the read pointer names debug control (address 0), both mailboxes are empty, `tdo` is 0 and `t2h_ready_o` is 1.
- R2: While `shift_dr` is high, each TCK moves the 38-bit frame one place toward bit 0, with `tdi` entering bit 37. `tdo` always shows frame bit 0. The three TAP strobes are never high together.
- R3: An update with frame bit 37 = 1 writes frame bits 31:0 into the register at address bits 36:32, keeping only the low bits that fit the register.
- R4: An update with bit 37 = 0 changes no register and only stores the address as the read pointer. A write frame leaves the pointer as it was. Capture-DR loads the pointed register into bits 31:0 and clears bits 37:32.
- R5: Register widths are: debug control 6 bits at address 0, vector catch 8 bits at address 2, and watch control value 9 bits and watch control mask 8 bits. The other watch registers are 32 bits wide. Captured bits above a register's width are 0.
- R6: `dbg_ctrl_o` shows the debug control register, and `mon_en_o` is its bit 4.
- R7: Address 1 returns `dbg_status_i` (5 bits) and ignores writes.
- R8: Addresses 3, 6, 7, watch offsets 6 and 7, and every address above the last watch unit read as 0 and ignore writes.
- R9: Address 4 is a read-only status word. Bit 0 = host-to-target word pending and bit 1 = target-to-host word available; all other bits are 0.
- R10: A write to address 5 loads `h2t_data_o` and raises `h2t_valid_o`. The word is held until a cycle with `h2t_ready_i` high. A write landing in the same cycle as that acceptance leaves the new word pending.
- R11: A word is taken from `t2h_data_i` when `t2h_valid_i` and `t2h_ready_o` are both high. `t2h_ready_o` is high when the mailbox is empty or when it is being consumed in that cycle. A capture while the pointer is 5 returns the stored word and empties the mailbox unless a new word enters in the same cycle.
- R12: Watch unit i occupies addresses 8(i+1) to 8(i+1)+5. In that range, offsets 0 to 5 hold address value, address mask, data value, data mask, control value and control mask, in that order. Each register drives its slice i of the matching output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low asynchronous reset |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| dbg_status_i | input | 5 | Debug status from the core |
| dbg_ctrl_o | output | 6 | Debug control register |
| mon_en_o | output | 1 | Monitor-mode enable |
| vec_catch_o | output | 8 | Vector-catch mask |
| wp_addr_val_o | output | 32*NUM_WATCH | Watch address values |
| wp_addr_msk_o | output | 32*NUM_WATCH | Watch address masks |
| wp_data_val_o | output | 32*NUM_WATCH | Watch data values |
| wp_data_msk_o | output | 32*NUM_WATCH | Watch data masks |
| wp_ctrl_val_o | output | 9*NUM_WATCH | Watch control values |
| wp_ctrl_msk_o | output | 8*NUM_WATCH | Watch control masks |
| h2t_valid_o | output | 1 | Host-to-target word valid |
| h2t_ready_i | input | 1 | Target accepts host word |
| h2t_data_o | output | 32 | Host-to-target word |
| t2h_valid_i | input | 1 | Target word valid |
| t2h_ready_o | output | 1 | Mailbox can take a target word |
| t2h_data_i | input | 32 | Target-to-host word |

## Verification
Two pairs of functions can fall in the same TCK cycle, one at each mailbox.

The first pair is a capture that consumes the target-to-host word and a new push from the target. The bench drives `t2h_valid_i` during the Capture-DR cycle of a scan whose pointer is 5. It judges the result in three ways: `t2h_ready_o` must be high in that cycle, the scan must return the old word, and the mailbox must report the new word as available.

The second pair is an Update-DR that writes a host word and the target accepting the previous word. The bench raises `h2t_ready_i` during that update. It expects `h2t_valid_o` to stay high with the new data.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;
  localparam int DW       = 32;
  localparam int AW       = 5;
  localparam int FRAME_W  = DW + AW + 1;
  localparam int CTRL_W   = 6;
  localparam int STAT_W   = 5;
  localparam int VEC_W    = 8;
  localparam int WCV_W    = 9;
  localparam int WCM_W    = 8;
  localparam int MON_BIT  = 4;
  localparam int WSHIFT   = 3;   // watch unit stride is 2**WSHIFT addresses
  localparam int OFS_W    = WSHIFT;

  localparam logic [AW-1:0] A_DBG_CTRL   = 5'd0;
  localparam logic [AW-1:0] A_DBG_STAT   = 5'd1;
  localparam logic [AW-1:0] A_VEC        = 5'd2;
  localparam logic [AW-1:0] A_COMMS_CTRL = 5'd4;
  localparam logic [AW-1:0] A_COMMS_DATA = 5'd5;

  typedef enum logic [OFS_W-1:0] {
    WO_AVAL = 3'd0,
    WO_AMSK = 3'd1,
    WO_DVAL = 3'd2,
    WO_DMSK = 3'd3,
    WO_CVAL = 3'd4,
    WO_CMSK = 3'd5
  } wofs_e;
endpackage

// File: rtl/jtag_dbg_shift.sv
module jtag_dbg_shift
  import jtag_dbg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               shift_en,
  input  logic               tdi,
  input  logic [DW-1:0]      cap_data,
  output logic [FRAME_W-1:0] frame,
  output logic               tdo
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (cap_en)   sr_q <= FRAME_W'(cap_data);
    else if (shift_en) sr_q <= {tdi, sr_q[FRAME_W-1:1]};
  end

  assign frame = sr_q;
  assign tdo   = sr_q[0];

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (sr_q[FRAME_W-2:0] == $past(sr_q[FRAME_W-1:1])) && (sr_q[FRAME_W-1] == $past(tdi))); // R2
  AST_CAPTURE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (sr_q[FRAME_W-1:DW] == '0) && (sr_q[DW-1:0] == $past(cap_data))); // R4
endmodule

// File: rtl/jtag_dbg_watch.sv
module jtag_dbg_watch
  import jtag_dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [DW-1:0]    wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    aval,
  output logic [DW-1:0]    amsk,
  output logic [DW-1:0]    dval,
  output logic [DW-1:0]    dmsk,
  output logic [WCV_W-1:0] cval,
  output logic [WCM_W-1:0] cmsk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aval <= '0; amsk <= '0; dval <= '0; dmsk <= '0; cval <= '0; cmsk <= '0;
    end else if (wr_en) begin
      case (wr_ofs)
        WO_AVAL: aval <= wr_data;
        WO_AMSK: amsk <= wr_data;
        WO_DVAL: dval <= wr_data;
        WO_DMSK: dmsk <= wr_data;
        WO_CVAL: cval <= wr_data[WCV_W-1:0];
        WO_CMSK: cmsk <= wr_data[WCM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_ofs)
      WO_AVAL: rd_data = aval;
      WO_AMSK: rd_data = amsk;
      WO_DVAL: rd_data = dval;
      WO_DMSK: rd_data = dmsk;
      WO_CVAL: rd_data = DW'(cval);
      WO_CMSK: rd_data = DW'(cmsk);
      default: rd_data = '0;
    endcase
  end

  AST_WATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(aval) && $stable(amsk) && $stable(dval) && $stable(dmsk) && $stable(cval) && $stable(cmsk)); // R12
endmodule

// File: rtl/jtag_dbg_comms.sv
module jtag_dbg_comms
  import jtag_dbg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h2t_wr,
  input  logic [DW-1:0] h2t_wdata,
  output logic          h2t_valid,
  input  logic          h2t_ready,
  output logic [DW-1:0] h2t_data,
  input  logic          t2h_valid,
  output logic          t2h_ready,
  input  logic [DW-1:0] t2h_data,
  input  logic          t2h_pop,
  output logic [DW-1:0] t2h_word,
  output logic          t2h_avail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2t_valid <= 1'b0;
      h2t_data  <= '0;
    end else if (h2t_wr) begin
      h2t_valid <= 1'b1;
      h2t_data  <= h2t_wdata;
    end else if (h2t_ready) begin
      h2t_valid <= 1'b0;
    end
  end

  assign t2h_ready = !t2h_avail || t2h_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2h_avail <= 1'b0;
      t2h_word  <= '0;
    end else if (t2h_valid && t2h_ready) begin
      t2h_avail <= 1'b1;
      t2h_word  <= t2h_data;
    end else if (t2h_pop) begin
      t2h_avail <= 1'b0;
    end
  end

  AST_H2T_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    h2t_wr |=> h2t_valid && (h2t_data == $past(h2t_wdata))); // R10
  AST_H2T_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (h2t_valid && !h2t_ready && !h2t_wr) |=> h2t_valid && $stable(h2t_data)); // R10
  AST_T2H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (t2h_avail && !t2h_pop) |=> t2h_avail && $stable(t2h_word)); // R11
  AST_T2H_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (t2h_valid && t2h_ready) |=> t2h_avail && (t2h_word == $past(t2h_data))); // R11
endmodule

// File: rtl/jtag_dbg_regs.sv
module jtag_dbg_regs
  import jtag_dbg_pkg::*;
#(
  parameter int NUM_WATCH = 2
) (
  input  logic                     tck,
  input  logic                     trst_n,
  input  logic                     cap_dr,
  input  logic                     shift_dr,
  input  logic                     upd_dr,
  input  logic                     tdi,
  output logic                     tdo,
  input  logic [STAT_W-1:0]        dbg_status_i,
  output logic [CTRL_W-1:0]        dbg_ctrl_o,
  output logic                     mon_en_o,
  output logic [VEC_W-1:0]         vec_catch_o,
  output logic [NUM_WATCH*DW-1:0]  wp_addr_val_o,
  output logic [NUM_WATCH*DW-1:0]  wp_addr_msk_o,
  output logic [NUM_WATCH*DW-1:0]  wp_data_val_o,
  output logic [NUM_WATCH*DW-1:0]  wp_data_msk_o,
  output logic [NUM_WATCH*WCV_W-1:0] wp_ctrl_val_o,
  output logic [NUM_WATCH*WCM_W-1:0] wp_ctrl_msk_o,
  output logic                     h2t_valid_o,
  input  logic                     h2t_ready_i,
  output logic [DW-1:0]            h2t_data_o,
  input  logic                     t2h_valid_i,
  output logic                     t2h_ready_o,
  input  logic [DW-1:0]            t2h_data_i
);
  localparam int UW = AW - WSHIFT;

  logic [FRAME_W-1:0] frame;
  logic [DW-1:0]      fr_data;
  logic [AW-1:0]      fr_addr;
  logic               fr_wr;
  logic               wr_stb;
  logic [AW-1:0]      rd_ptr_q;
  logic [DW-1:0]      rd_word;
  logic [DW-1:0]      watch_rd;
  logic [CTRL_W-1:0]  dbg_ctrl_q;
  logic [VEC_W-1:0]   vec_q;
  logic               t2h_pop;
  logic [DW-1:0]      t2h_word;
  logic               t2h_avail;
  logic [DW-1:0]      wrd [NUM_WATCH];

  assign fr_data = frame[DW-1:0];
  assign fr_addr = frame[DW+AW-1:DW];
  assign fr_wr   = frame[FRAME_W-1];
  assign wr_stb  = upd_dr && fr_wr;
  assign t2h_pop = cap_dr && (rd_ptr_q == A_COMMS_DATA);

  jtag_dbg_shift u_shift (
    .clk(tck), .rst_n(trst_n), .cap_en(cap_dr), .shift_en(shift_dr),
    .tdi(tdi), .cap_data(rd_word), .frame(frame), .tdo(tdo)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               rd_ptr_q <= A_DBG_CTRL;
    else if (upd_dr && !fr_wr) rd_ptr_q <= fr_addr;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dbg_ctrl_q <= '0;
      vec_q      <= '0;
    end else if (wr_stb) begin
      if (fr_addr == A_DBG_CTRL) dbg_ctrl_q <= fr_data[CTRL_W-1:0];
      if (fr_addr == A_VEC)      vec_q      <= fr_data[VEC_W-1:0];
    end
  end

  assign dbg_ctrl_o  = dbg_ctrl_q;
  assign mon_en_o    = dbg_ctrl_q[MON_BIT];
  assign vec_catch_o = vec_q;

  for (genvar i = 0; i < NUM_WATCH; i++) begin : g_watch
    logic hit_w;
    assign hit_w = wr_stb && (fr_addr[AW-1:WSHIFT] == UW'(i + 1));
    jtag_dbg_watch u_watch (
      .clk(tck), .rst_n(trst_n),
      .wr_en(hit_w), .wr_ofs(fr_addr[WSHIFT-1:0]), .wr_data(fr_data),
      .rd_ofs(rd_ptr_q[WSHIFT-1:0]), .rd_data(wrd[i]),
      .aval(wp_addr_val_o[i*DW +: DW]), .amsk(wp_addr_msk_o[i*DW +: DW]),
      .dval(wp_data_val_o[i*DW +: DW]), .dmsk(wp_data_msk_o[i*DW +: DW]),
      .cval(wp_ctrl_val_o[i*WCV_W +: WCV_W]), .cmsk(wp_ctrl_msk_o[i*WCM_W +: WCM_W])
    );
  end

  jtag_dbg_comms u_comms (
    .clk(tck), .rst_n(trst_n),
    .h2t_wr(wr_stb && (fr_addr == A_COMMS_DATA)), .h2t_wdata(fr_data),
    .h2t_valid(h2t_valid_o), .h2t_ready(h2t_ready_i), .h2t_data(h2t_data_o),
    .t2h_valid(t2h_valid_i), .t2h_ready(t2h_ready_o), .t2h_data(t2h_data_i),
    .t2h_pop(t2h_pop), .t2h_word(t2h_word), .t2h_avail(t2h_avail)
  );

  always_comb begin
    watch_rd = '0;
    for (int i = 0; i < NUM_WATCH; i++) begin
      if (rd_ptr_q[AW-1:WSHIFT] == UW'(i + 1)) watch_rd = watch_rd | wrd[i];
    end
  end

  always_comb begin
    case (rd_ptr_q)
      A_DBG_CTRL:   rd_word = DW'(dbg_ctrl_q);
      A_DBG_STAT:   rd_word = DW'(dbg_status_i);
      A_VEC:        rd_word = DW'(vec_q);
      A_COMMS_CTRL: rd_word = DW'({t2h_avail, h2t_valid_o});
      A_COMMS_DATA: rd_word = t2h_word;
      default:      rd_word = watch_rd;
    endcase
  end

  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({cap_dr, shift_dr, upd_dr})); // R2
  AST_PTR_ON_WRITE: assert property (@(posedge tck) disable iff (!trst_n)
    wr_stb |=> $stable(rd_ptr_q)); // R4
  AST_MON_SOURCE: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(mon_en_o) |-> $past(wr_stb && (fr_addr == A_DBG_CTRL) && fr_data[MON_BIT])); // R6
  AST_STATUS_RO: assert property (@(posedge tck) disable iff (!trst_n)
    (wr_stb && (fr_addr == A_COMMS_CTRL) && !h2t_valid_o) |=> !h2t_valid_o); // R9
endmodule

// File: tb/jtag_dbg_regs_bench.sv
module jtag_dbg_regs_bench;
  localparam int TCK_PERIOD = 10;
  localparam int NW = 2;

  logic tck = 0, trst_n = 0, cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0;
  logic tdo;
  logic [4:0] dbg_status_i = 5'h15;
  logic [5:0] dbg_ctrl_o;
  logic mon_en_o;
  logic [7:0] vec_catch_o;
  logic [NW*32-1:0] wav, wam, wdv, wdm;
  logic [NW*9-1:0] wcv;
  logic [NW*8-1:0] wcm;
  logic h2t_valid_o, h2t_ready_i = 0;
  logic [31:0] h2t_data_o;
  logic t2h_valid_i = 0, t2h_ready_o;
  logic [31:0] t2h_data_i = 0;

  int n_chk = 0, n_fail = 0;
  bit acc_at_upd = 0, push_at_cap = 0;
  logic [31:0] push_word = 0;
  logic cap_ready_seen = 0;
  logic [31:0] model [32];

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_dbg_regs #(.NUM_WATCH(NW)) u_jtag_dbg_regs (
    .tck(tck), .trst_n(trst_n), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
    .tdi(tdi), .tdo(tdo), .dbg_status_i(dbg_status_i), .dbg_ctrl_o(dbg_ctrl_o),
    .mon_en_o(mon_en_o), .vec_catch_o(vec_catch_o),
    .wp_addr_val_o(wav), .wp_addr_msk_o(wam), .wp_data_val_o(wdv), .wp_data_msk_o(wdm),
    .wp_ctrl_val_o(wcv), .wp_ctrl_msk_o(wcm),
    .h2t_valid_o(h2t_valid_o), .h2t_ready_i(h2t_ready_i), .h2t_data_o(h2t_data_o),
    .t2h_valid_i(t2h_valid_i), .t2h_ready_o(t2h_ready_o), .t2h_data_i(t2h_data_i)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int a);
    int o;
    if (a == 0) return 32'h3F;
    if (a == 2) return 32'hFF;
    if (a >= 8 && a < 8 * (NW + 1)) begin
      o = a % 8;
      if (o < 4) return 32'hFFFF_FFFF;
      if (o == 4) return 32'h1FF;
      if (o == 5) return 32'hFF;
    end
    return 32'h0;
  endfunction

  task automatic scan(input logic [37:0] fin, output logic [37:0] fout);
    @(negedge tck);
    cap_dr = 1;
    if (push_at_cap) begin
      t2h_valid_i = 1; t2h_data_i = push_word;
      #1 cap_ready_seen = t2h_ready_o;
    end
    @(negedge tck);
    cap_dr = 0; t2h_valid_i = 0; shift_dr = 1;
    for (int i = 0; i < 38; i++) begin
      tdi = fin[i];
      fout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 0; upd_dr = 1;
    if (acc_at_upd) h2t_ready_i = 1;
    @(negedge tck);
    upd_dr = 0;
    if (acc_at_upd) h2t_ready_i = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] junk;
    scan({1'b1, a, d}, junk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    logic [37:0] junk, f;
    scan({1'b0, a, 32'h0}, junk);
    scan({1'b0, 5'd4, 32'h0}, f);
    check("R4 capture clears address/flag", {58'h0, f[37:32]}, 64'h0);
    d = f[31:0];
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge tck);
    t2h_valid_i = 1; t2h_data_i = w;
    #1 check("R11 ready before push", {63'h0, t2h_ready_o}, 64'h1);
    @(negedge tck);
    t2h_valid_i = 0;
    check("R11 ready drops when full", {63'h0, t2h_ready_o}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [37:0] f, f2;
    logic [31:0] d, p, e;
    for (int a = 0; a < 32; a++) model[a] = 0;
    repeat (3) @(negedge tck);
    trst_n = 1;
    @(negedge tck);
    // R1 reset state
    check("R1 tdo", {63'h0, tdo}, 64'h0);
    check("R1 dbg_ctrl", {58'h0, dbg_ctrl_o}, 64'h0);
    check("R1 h2t_valid", {63'h0, h2t_valid_o}, 64'h0);
    check("R1 t2h_ready", {63'h0, t2h_ready_o}, 64'h1);
    scan({1'b1, 5'd0, 32'hFFFF_FFD5}, f);
    check("R1 first capture is debug control", {32'h0, f[31:0]}, 64'h0);
    scan({1'b1, 5'd2, 32'h0}, f);
    check("R1 reset pointer names debug control", {32'h0, f[31:0]}, 64'h15);
    check("R6 monitor enable set", {63'h0, mon_en_o}, 64'h1);
    check("R6 dbg_ctrl_o", {58'h0, dbg_ctrl_o}, 64'h15);
    wr(5'd0, 32'h2F);
    check("R6 monitor enable clear", {63'h0, mon_en_o}, 64'h0);
    wr(5'd0, 32'h0);

    // R3/R5/R7/R8/R12 sweep over the address space, two patterns
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 32; a++) begin
        if (a == 5) continue;
        p = 32'h9E37_79B9 * (a + 1);
        if (pass == 1) p = ~p;
        wr(5'(a), p);
        model[a] = p & wmask(a);
      end
      for (int a = 0; a < 32; a++) begin
        if (a == 5) continue;
        rd(5'(a), d);
        if (a == 1)      e = 32'h15;
        else if (a == 4) e = 32'h0;
        else             e = model[a];
        if (a == 1)             check("R7 status read, write ignored", {32'h0, d}, {32'h0, e});
        else if (a == 4)        check("R9 comms status read-only", {32'h0, d}, {32'h0, e});
        else if (wmask(a) == 0) check("R8 unused reads zero", {32'h0, d}, {32'h0, e});
        else if (a >= 8)        check("R12 watch register readback", {32'h0, d}, {32'h0, e});
        else                    check("R5 width truncation readback", {32'h0, d}, {32'h0, e});
      end
      check("R3 dbg_ctrl_o", {58'h0, dbg_ctrl_o}, {32'h0, model[0]});
      check("R3 vec_catch_o", {56'h0, vec_catch_o}, {32'h0, model[2]});
      check("R12 unit0 addr value", {32'h0, wav[31:0]}, {32'h0, model[8]});
      check("R12 unit1 addr mask", {32'h0, wam[63:32]}, {32'h0, model[17]});
      check("R12 unit0 data mask", {32'h0, wdm[31:0]}, {32'h0, model[11]});
      check("R12 unit1 data value", {32'h0, wdv[63:32]}, {32'h0, model[18]});
      check("R12 unit0 ctrl value", {55'h0, wcv[8:0]}, {32'h0, model[12]});
      check("R12 unit1 ctrl mask", {56'h0, wcm[15:8]}, {32'h0, model[21]});
    end

    // R4 pointer unchanged by a write frame
    scan({1'b0, 5'd2, 32'h0}, f);
    scan({1'b1, 5'd0, 32'h3}, f);
    check("R4 capture after read frame", {32'h0, f[31:0]}, {32'h0, model[2]});
    scan({1'b0, 5'd4, 32'h0}, f2);
    check("R4 write frame keeps pointer", {32'h0, f2[31:0]}, {32'h0, model[2]});

    // R10 host-to-target mailbox
    wr(5'd5, 32'hCAFE_0001);
    check("R10 valid after write", {63'h0, h2t_valid_o}, 64'h1);
    check("R10 data after write", {32'h0, h2t_data_o}, 64'hCAFE_0001);
    rd(5'd4, d);
    check("R9 pending bit", {32'h0, d}, 64'h1);
    check("R10 held without ready", {63'h0, h2t_valid_o}, 64'h1);
    acc_at_upd = 1;
    wr(5'd5, 32'hCAFE_0002);
    acc_at_upd = 0;
    check("R10 write with accept keeps valid", {63'h0, h2t_valid_o}, 64'h1);
    check("R10 write with accept new data", {32'h0, h2t_data_o}, 64'hCAFE_0002);
    @(negedge tck); h2t_ready_i = 1;
    @(negedge tck); h2t_ready_i = 0;
    check("R10 accept clears valid", {63'h0, h2t_valid_o}, 64'h0);

    // R11 target-to-host mailbox
    push(32'h1234_5678);
    rd(5'd4, d);
    check("R9 available bit", {32'h0, d}, 64'h2);
    rd(5'd5, d);
    check("R11 read word", {32'h0, d}, 64'h1234_5678);
    rd(5'd4, d);
    check("R11 read empties mailbox", {32'h0, d}, 64'h0);
    check("R11 ready after pop", {63'h0, t2h_ready_o}, 64'h1);
    push(32'hAAAA_0001);
    scan({1'b0, 5'd5, 32'h0}, f);
    push_at_cap = 1; push_word = 32'hBBBB_0002;
    scan({1'b0, 5'd4, 32'h0}, f);
    push_at_cap = 0;
    check("R11 ready during consuming capture", {63'h0, cap_ready_seen}, 64'h1);
    check("R11 capture returns old word", {32'h0, f[31:0]}, 64'hAAAA_0001);
    rd(5'd4, d);
    check("R11 new word stays available", {32'h0, d}, 64'h2);
    rd(5'd5, d);
    check("R11 new word read", {32'h0, d}, 64'hBBBB_0002);
    push(32'hC0DE_0003);
    scan({1'b0, 5'd5, 32'h0}, f);
    scan({1'b0, 5'd5, 32'h0}, f);
    check("R11 capture at pointer 5", {32'h0, f[31:0]}, 64'hC0DE_0003);
    scan({1'b0, 5'd4, 32'h0}, f);
    check("R11 second capture finds empty", {63'h0, t2h_ready_o}, 64'h1);
    scan({1'b0, 5'd4, 32'h0}, f);
    check("R9 status empty after double read", {32'h0, f[31:0]}, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule